// File: doc/BRIEF.md
# Write-Verify Controller for a Resistive Memory Cell

This block runs every write to a resistive non-volatile bit through a check-first loop. A request carries an address and a one-bit value. The controller first reads the cell. If the stored value already matches, it finishes without disturbing the cell. If it does not match, it fires a write pulse and reads again. It repeats this pulse-and-read pair until the value reads back correctly or a trial budget runs out. Each new pulse drives the cell harder than the previous one.

On the cell side the block drives a read strobe, a write enable, a current-direction line and three drive-strength lines. It samples a one-bit read result. On the requester side it offers a valid/ready handshake. It reports a one-cycle completion pulse with a failure flag and the number of write pulses spent, so the energy and latency of each write can be observed.

Top module: `wv_write_ctrl`

## Requirements
- R1: Out of reset, req_ready is high, and done, fail, cell_wr_en and cell_rd_strobe are all low.
- R2: req_ready drops in the cycle after a request is accepted and stays low until the cycle in which done is high. done lasts exactly one cycle, and req_ready is high again in the next cycle.
- R3: Every operation starts with a verify read lasting READ_WAIT cycles with cell_rd_strobe high. If the sampled cell_rd_data equals the requested bit, done is raised with trials equal to 0 and no write pulse is issued.
- R4: After a verify that mismatches, one write pulse follows, with cell_wr_en high for exactly PULSE_CYC cycles. A verify read then starts immediately after the pulse.
- R5: During a pulse, cell_wr_dir equals the requested bit (1 drives current from source line to bit line, 0 the reverse). cell_wr_en is never high together with cell_rd_strobe, and it is low outside pulses.
- R6: cell_sel bit k is strength line k. Pulse 1 uses 3'b001, pulse 2 uses 3'b011, and pulse 3 and every later pulse use 3'b111. The value is held steady for the whole pulse and is 0 outside pulses.
- R7: When a verify matches after n pulses, done is raised with fail low and trials equal to n. done arrives READ_WAIT + n*(PULSE_CYC+READ_WAIT) + 1 cycles after the accepting edge.
- R8: If the verify after the MAX_TRIALS-th pulse still mismatches, done is raised with fail high and trials equal to MAX_TRIALS. No further pulse is issued.
- R9: The address and bit are captured when the request is accepted. cell_addr holds the captured address for the whole operation, and changes on req_addr or req_data after acceptance have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Controller idle; a request is taken when valid and ready are both high |
| req_addr | input | AW | Target cell address |
| req_data | input | 1 | Bit to store |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Trial budget exhausted; valid with done |
| trials | output | $clog2(MAX_TRIALS+1) | Write pulses used by the last operation |
| cell_addr | output | AW | Address presented to the cell array |
| cell_rd_strobe | output | 1 | Verify read in progress |
| cell_rd_data | input | 1 | Sensed cell value |
| cell_wr_en | output | 1 | Write current enabled |
| cell_wr_dir | output | 1 | Write current direction (1: source to bit line) |
| cell_sel | output | 3 | Drive-strength lines, one bit per line |

## Verification
The results of an operation come from its path through the loop. done with fail and trials is due READ_WAIT + n*(PULSE_CYC+READ_WAIT) + 1 cycles after acceptance, where n is the pulse count. Each pulse's strength, direction and address are due at the first cycle its enable is high, and the pulse's end is due PULSE_CYC cycles later. The bench samples on falling edges. It counts the low-ready cycles up to and including the done cycle, checks every pulse as it starts and ends, and compares these against an expected item that the driver computes from the behavioural cell's switching threshold.

// File: rtl/wv_pkg.sv
package wv_pkg;

  localparam int unsigned SEL_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } wv_state_e;

  // Strength mask for a 1-based pulse number: one more line per pulse,
  // saturating once every line is on.
  function automatic logic [SEL_W-1:0] drive_mask(input int unsigned pulse_no);
    logic [SEL_W-1:0] m;
    for (int unsigned i = 0; i < SEL_W; i++) begin
      m[i] = (pulse_no > i);
    end
    return m;
  endfunction

endpackage

// File: rtl/wv_phase_timer.sv
module wv_phase_timer #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;

  logic [CW-1:0] cnt;

  assign last = run && (cnt == CW'(LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (run && !last) begin
      cnt <= cnt + CW'(1);
    end else begin
      cnt <= '0;
    end
  end
endmodule

// File: rtl/wv_drive_sel.sv
module wv_drive_sel #(
  parameter int unsigned TW = 4
) (
  input  logic                     active,
  input  logic [TW-1:0]            pulse_no,
  output logic [wv_pkg::SEL_W-1:0] sel
);
  always_comb begin
    if (active) begin
      sel = wv_pkg::drive_mask(int'(pulse_no));
    end else begin
      sel = '0;
    end
  end
endmodule

// File: rtl/wv_write_ctrl.sv
module wv_write_ctrl #(
  parameter int unsigned AW         = 8,
  parameter int unsigned MAX_TRIALS = 8,
  parameter int unsigned PULSE_CYC  = 4,
  parameter int unsigned READ_WAIT  = 3,
  localparam int unsigned TW        = $clog2(MAX_TRIALS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [AW-1:0]            req_addr,
  input  logic                     req_data,
  output logic                     done,
  output logic                     fail,
  output logic [TW-1:0]            trials,
  output logic [AW-1:0]            cell_addr,
  output logic                     cell_rd_strobe,
  input  logic                     cell_rd_data,
  output logic                     cell_wr_en,
  output logic                     cell_wr_dir,
  output logic [wv_pkg::SEL_W-1:0] cell_sel
);
  import wv_pkg::*;

  wv_state_e     state_q;
  logic [AW-1:0] addr_q;
  logic          data_q;
  logic [TW-1:0] trials_q;
  logic          fail_q;

  // named internal events
  logic accept;
  logic rd_last;
  logic wr_last;
  logic verify_ok;
  logic limit_hit;
  logic in_read;
  logic in_write;

  assign in_read   = (state_q == ST_READ);
  assign in_write  = (state_q == ST_WRITE);
  assign accept    = req_valid && (state_q == ST_IDLE);
  assign verify_ok = (cell_rd_data == data_q);
  assign limit_hit = (trials_q == TW'(MAX_TRIALS));

  wv_phase_timer #(.LEN(READ_WAIT)) u_rd_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (in_read),
    .last (rd_last)
  );

  wv_phase_timer #(.LEN(PULSE_CYC)) u_wr_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (in_write),
    .last (wr_last)
  );

  wv_drive_sel #(.TW(TW)) u_sel (
    .active  (in_write),
    .pulse_no(trials_q),
    .sel     (cell_sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      data_q   <= 1'b0;
      trials_q <= '0;
      fail_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            addr_q   <= req_addr;
            data_q   <= req_data;
            trials_q <= '0;
            fail_q   <= 1'b0;
            state_q  <= ST_READ;
          end
        end
        ST_READ: begin
          if (rd_last) begin
            if (verify_ok) begin
              state_q <= ST_DONE;
            end else if (limit_hit) begin
              fail_q  <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              trials_q <= trials_q + TW'(1);
              state_q  <= ST_WRITE;
            end
          end
        end
        ST_WRITE: begin
          if (wr_last) begin
            state_q <= ST_READ;
          end
        end
        default: begin
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign req_ready      = (state_q == ST_IDLE);
  assign done           = (state_q == ST_DONE);
  assign fail           = fail_q;
  assign trials         = trials_q;
  assign cell_addr      = addr_q;
  assign cell_rd_strobe = in_read;
  assign cell_wr_en     = in_write;
  assign cell_wr_dir    = in_write && data_q;

  // R5
  wr_rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_wr_en |-> !cell_rd_strobe);

  // R2
  done_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  // R8
  fail_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fail) |-> (trials == TW'(MAX_TRIALS)));

  // R4
  pulse_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cell_wr_en) |-> cell_rd_strobe);

  // R6
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_wr_en && $past(cell_wr_en)) |-> ($stable(cell_sel) && $stable(cell_wr_dir)));

  // R6
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_wr_en |-> (cell_sel == '0));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(cell_addr));

endmodule

// File: tb/wv_write_ctrl_tb.sv
`timescale 1ns/1ps
module wv_write_ctrl_tb;
  localparam int AW   = 8;
  localparam int MAXT = 8;
  localparam int PW   = 4;
  localparam int RW   = 3;
  localparam int TW   = $clog2(MAXT + 1);
  localparam int WD   = 20000;

  typedef struct {
    logic [AW-1:0] addr;
    logic          data;
    int            trials;
    logic          fail;
    int            lat;
  } exp_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic          req_data;
  logic          done;
  logic          fail;
  logic [TW-1:0] trials;
  logic [AW-1:0] cell_addr;
  logic          cell_rd_strobe;
  logic          cell_rd_data;
  logic          cell_wr_en;
  logic          cell_wr_dir;
  logic [2:0]    cell_sel;

  wv_write_ctrl #(
    .AW(AW), .MAX_TRIALS(MAXT), .PULSE_CYC(PW), .READ_WAIT(RW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .done(done), .fail(fail),
    .trials(trials), .cell_addr(cell_addr), .cell_rd_strobe(cell_rd_strobe),
    .cell_rd_data(cell_rd_data), .cell_wr_en(cell_wr_en),
    .cell_wr_dir(cell_wr_dir), .cell_sel(cell_sel)
  );

  // behavioural cell array (written only by the monitor process)
  logic [255:0] mem = '0;
  assign cell_rd_data = mem[cell_addr];

  // driver-owned state
  exp_t         exp_arr [0:31];
  int           n_sent = 0;
  int           need_q = 1;
  int           minstr_q = 1;
  logic [255:0] shadow = '0;

  // monitor-owned state
  int   n_done = 0;
  int   total = 0;
  int   bad = 0;
  int   cyc = 0;
  int   lat = 0;
  int   pidx = 0;
  int   plen = 0;
  int   qual = 0;
  bit   prev_en = 0;
  bit   prev_done = 0;
  bit   reset_checked = 0;
  bit   wd_hit = 0;

  function automatic logic [2:0] exp_sel(input int p);
    if (p >= 3) return 3'b111;
    if (p == 2) return 3'b011;
    return 3'b001;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, expv);
    end
  endtask

  // scoreboard monitor and cell model
  always @(negedge clk) begin
    exp_t e;
    cyc++;
    if (cyc == WD && !wd_hit) begin
      wd_hit = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", n_done, n_sent);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (rst_n) begin
      if (!reset_checked) begin
        reset_checked = 1;
        chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        chk(done == 1'b0 && fail == 1'b0, "R1", "done/fail after reset", int'({done, fail}), 0);
        chk(cell_wr_en == 1'b0 && cell_rd_strobe == 1'b0, "R1", "cell strobes after reset",
            int'({cell_wr_en, cell_rd_strobe}), 0);
      end
      if (prev_done) begin
        chk(!done && req_ready, "R2", "done single cycle then ready", int'({done, req_ready}), 1);
      end
      e = exp_arr[n_done];
      if (cell_wr_en && !prev_en) begin
        pidx++;
        chk(cell_sel == exp_sel(pidx), "R6", "strength select", int'(cell_sel), int'(exp_sel(pidx)));
        chk(cell_wr_dir == e.data, "R5", "current direction", int'(cell_wr_dir), int'(e.data));
        chk(cell_addr == e.addr, "R9", "cell address during pulse", int'(cell_addr), int'(e.addr));
        if ($countones(cell_sel) >= minstr_q) qual++;
        if (qual >= need_q) mem[cell_addr] = cell_wr_dir;
      end
      if (cell_wr_en) plen++;
      if (!cell_wr_en && prev_en) begin
        chk(plen == PW, "R4", "pulse length", plen, PW);
        chk(cell_rd_strobe == 1'b1, "R4", "read after pulse", int'(cell_rd_strobe), 1);
        plen = 0;
      end
      lat = req_ready ? 0 : lat + 1;
      if (done) begin
        chk(req_ready == 1'b0, "R2", "ready low at done", int'(req_ready), 0);
        chk(int'(trials) == e.trials, e.fail ? "R8" : "R7", "trial count", int'(trials), e.trials);
        chk(fail == e.fail, e.fail ? "R8" : "R7", "fail flag", int'(fail), int'(e.fail));
        chk(lat == e.lat, "R7", "latency to done", lat, e.lat);
        chk(pidx == e.trials, "R3", "pulses issued", pidx, e.trials);
        chk(cell_addr == e.addr, "R9", "cell address at done", int'(cell_addr), int'(e.addr));
        n_done++;
        pidx = 0;
        qual = 0;
      end
      prev_en   = cell_wr_en;
      prev_done = done;
    end
  end

  // driver: computes the expected item from the cell threshold and pushes it
  task automatic op(input logic [AW-1:0] addr, input logic data,
                    input int need, input int minstr);
    exp_t e;
    int q;
    e.addr = addr;
    e.data = data;
    e.trials = MAXT;
    e.fail = 1'b1;
    if (shadow[addr] == data) begin
      e.trials = 0;
      e.fail = 1'b0;
    end else begin
      q = 0;
      for (int i = 1; i <= MAXT; i++) begin
        if (((i >= 3) ? 3 : i) >= minstr) q++;
        if (q >= need && e.fail) begin
          e.trials = i;
          e.fail = 1'b0;
        end
      end
    end
    if (!e.fail) shadow[addr] = data;
    e.lat = RW + e.trials * (PW + RW) + 1;
    while (!req_ready) @(negedge clk);
    need_q = need;
    minstr_q = minstr;
    exp_arr[n_sent] = e;
    n_sent++;
    req_addr  = addr;
    req_data  = data;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = addr ^ 8'hFF;   // R9: post-acceptance changes must be ignored
    req_data  = ~data;
    while (n_done < n_sent) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    req_data = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    op(8'd5,   1'b0, 1,   1);  // R3 already stored
    op(8'd5,   1'b1, 1,   1);  // R7 one pulse
    op(8'd6,   1'b1, 2,   3);  // R6 needs full strength twice
    op(8'd5,   1'b0, 1,   2);  // R5 reverse direction
    op(8'd9,   1'b1, 1,   1);
    op(8'd9,   1'b0, 100, 1);  // R8 never switches
    op(8'd9,   1'b0, 3,   1);  // fail flag clears on next op
    op(8'd6,   1'b1, 1,   1);  // R3 match, no pulse
    op(8'd200, 1'b1, 6,   3);  // success on the last allowed pulse
    op(8'd201, 1'b1, 7,   3);  // R8 one short
    repeat (3) @(negedge clk);
    if (!wd_hit) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule